// File: doc/BRIEF.md
# LCD Common Row Scan Sequencer

This block drives the common (row) electrodes of a multiplexed LCD. It keeps a row pointer that steps forward by one on each row-period tick from the frame timing logic, and it decodes that pointer into a one-hot set of row-select lines. Three multiplex arrangements are supported. The 32-way arrangement scans the two row groups back to back. The 16-way arrangement scans one group, either the lower or the upper one, chosen by a remap input. The 33-way arrangement scans both groups and then an extra icon row. The icon row drives two identical output pins so that panel routing can reach it from either side.

The multiplex mode and remap are sampled at reset and at every frame wrap, so a frame that is already running is never cut short or rearranged. The scan always restarts at the first row of the newly sampled arrangement. A one-cycle frame-start pulse marks each wrap. A display-enable input blanks every row line at once without stopping the scan, so timing is kept while the panel is dark. The row group size is a parameter, `GROUP_ROWS`, with a default of 16. That gives 33 row lines, where row `2*GROUP_ROWS` is the icon row.

Top module: `lcd_com_scan`

## Requirements
- R1: `muxMode` is coded 2'b00 = 16-way, 2'b01 = 32-way, 2'b10 = 33-way, and 2'b11 behaves as 32-way. In 32-way operation, rows 0 through 2*GROUP_ROWS-1 are scanned in ascending order.
- R2: In 16-way operation with `remap` low, only rows 0 through GROUP_ROWS-1 are scanned, in ascending order.
- R3: In 16-way operation with `remap` high, only rows GROUP_ROWS through 2*GROUP_ROWS-1 are scanned, in ascending order.
- R4: In 33-way operation, rows 0 through 2*GROUP_ROWS are scanned, and the icon row 2*GROUP_ROWS is the last row. The icon row is never selected in any other mode.
- R5: `iconRowA` and `iconRowB` always equal `rowSel[2*GROUP_ROWS]`.
- R6: While `displayOn` is low, every bit of `rowSel` and both icon outputs are 0. The row pointer keeps advancing, so the lines return at the row reached by the scan.
- R7: Each clock with `rowTick` high moves the selection to the next row. A clock with `rowTick` low leaves the selection unchanged.
- R8: A tick on the last row of the sampled arrangement wraps to its first row. `frameStart` is high for exactly the one cycle in which that first row is presented after a wrap, and low at all other times.
- R9: While `rst` is high at a clock edge, the scan is placed on the first row of the mode and remap present at its inputs, and `frameStart` is low.
- R10: A change of `muxMode` or `remap` has no effect on the scan until the next frame wrap. At that wrap, the new setting chooses the first row and the range.
- R11: At most one bit of `rowSel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rowTick | input | 1 | Row-period strobe; advances the scan by one row |
| muxMode | input | 2 | Multiplex arrangement: 00 16-way, 01 32-way, 10 33-way, 11 as 32-way |
| remap | input | 1 | Selects the upper row group in 16-way operation |
| displayOn | input | 1 | Low blanks every row output |
| rowSel | output | 2*GROUP_ROWS+1 | One-hot row-select lines; the top bit is the icon row |
| iconRowA | output | 1 | Icon row line, first pin |
| iconRowB | output | 1 | Icon row line, second pin, identical to the first |
| frameStart | output | 1 | One-cycle pulse with the first row of each new frame |

## Verification
The bench builds the sequencer with `GROUP_ROWS` set to 4, so there are nine row lines and the icon row is bit 8. At that size, every frame of every mode fits in a few cycles. This lets the bench run each mode and remap combination through several complete frames, with the display both on and off and with tick gaps. It also covers every ordered pair of arrangements changed in the middle of a frame. Expected row positions are worked out from the range arithmetic in the requirements, and every output is compared in every cycle.

// File: rtl/lcd_com_scan_pkg.sv
package lcd_com_scan_pkg;

  // Wide enough for any row index the block supports (up to 255 rows).
  localparam int MAX_IDX_W = 8;

  typedef enum logic [1:0] {
    MUX_16  = 2'b00,
    MUX_32  = 2'b01,
    MUX_33  = 2'b10,
    MUX_RSV = 2'b11
  } muxMode_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic                 load;      // put the pointer on loadIdx
    logic                 inc;       // move the pointer up by one row
    logic                 wrap;      // the load ends a frame
    logic [MAX_IDX_W-1:0] loadIdx;   // first row of the new arrangement
  } scanStrobe_t;

  // First row of an arrangement.
  function automatic int firstRowOf(muxMode_e mode, logic remapSel, int groupRows);
    if (mode == MUX_16 && remapSel) return groupRows;
    return 0;
  endfunction

  // Last row of an arrangement.
  function automatic int lastRowOf(muxMode_e mode, logic remapSel, int groupRows);
    case (mode)
      MUX_16:  return remapSel ? (2 * groupRows - 1) : (groupRows - 1);
      MUX_33:  return 2 * groupRows;
      default: return 2 * groupRows - 1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_com_scan_ctrl.sv
module lcd_com_scan_ctrl
  import lcd_com_scan_pkg::*;
#(
  parameter int GROUP_ROWS = 16,
  localparam int NUM_ROWS  = 2 * GROUP_ROWS + 1,
  localparam int IDX_W     = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rowTick,
  input  logic [1:0]       muxMode,
  input  logic             remap,
  input  logic [IDX_W-1:0] rowIdx,
  output scanStrobe_t      strobe,
  output muxMode_e         cfgMode,
  output logic             cfgRemap
);

  muxMode_e         modeIn;
  logic [IDX_W-1:0] lastIdx;
  logic             atLast;
  logic             wrapNow;
  logic             sampleCfg;

  assign modeIn    = muxMode_e'(muxMode);
  assign lastIdx   = IDX_W'(lastRowOf(cfgMode, cfgRemap, GROUP_ROWS));
  assign atLast    = (rowIdx == lastIdx);
  assign wrapNow   = !rst && rowTick && atLast;
  assign sampleCfg = rst || wrapNow;

  // The configuration is only taken in at reset or at a frame boundary.
  always_ff @(posedge clk) begin
    if (sampleCfg) begin
      cfgMode  <= modeIn;
      cfgRemap <= remap;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.loadIdx = MAX_IDX_W'(firstRowOf(modeIn, remap, GROUP_ROWS));
    if (rst) begin
      strobe.load = 1'b1;
    end else if (rowTick) begin
      if (atLast) begin
        strobe.load = 1'b1;
        strobe.wrap = 1'b1;
      end else begin
        strobe.inc = 1'b1;
      end
    end
  end

  // R10: the arrangement in use only changes at a wrap.
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(rowTick && atLast) |=> ($stable(cfgMode) && $stable(cfgRemap)));

  // R7: load and increment never happen together.
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load && strobe.inc));

endmodule

// File: rtl/lcd_com_scan_dp.sv
module lcd_com_scan_dp
  import lcd_com_scan_pkg::*;
#(
  parameter int GROUP_ROWS = 16,
  localparam int NUM_ROWS  = 2 * GROUP_ROWS + 1,
  localparam int IDX_W     = $clog2(NUM_ROWS),
  localparam int ICON_ROW  = 2 * GROUP_ROWS
) (
  input  logic                clk,
  input  logic                rst,
  input  scanStrobe_t         strobe,
  input  logic                displayOn,
  output logic [IDX_W-1:0]    rowIdx,
  output logic [NUM_ROWS-1:0] rowSel,
  output logic                iconRowA,
  output logic                iconRowB,
  output logic                frameStart
);

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      rowIdx <= strobe.loadIdx[IDX_W-1:0];
    end else if (strobe.inc) begin
      rowIdx <= rowIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) frameStart <= 1'b0;
    else     frameStart <= strobe.wrap;
  end

  // One comparator per row line, gated by the display enable.
  for (genvar g = 0; g < NUM_ROWS; g++) begin : gRowDec
    assign rowSel[g] = displayOn && (rowIdx == IDX_W'(g));
  end

  // The icon row is fanned out to both pins.
  logic [1:0] iconPins;
  for (genvar p = 0; p < 2; p++) begin : gIconPin
    assign iconPins[p] = rowSel[ICON_ROW];
  end
  assign iconRowA = iconPins[0];
  assign iconRowB = iconPins[1];

  // R7: no tick means the pointer holds.
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load || strobe.inc) |=> $stable(rowIdx));

  // R7: an increment moves the pointer by exactly one.
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.inc |=> (rowIdx == $past(rowIdx) + IDX_W'(1)));

  // R11: never more than one row line active.
  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rowSel));

  // R8: the frame pulse lasts a single cycle.
  assert_fs_single_R8: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_com_scan_pkg::*;
#(
  parameter int GROUP_ROWS = 16,
  localparam int NUM_ROWS  = 2 * GROUP_ROWS + 1,
  localparam int IDX_W     = $clog2(NUM_ROWS),
  localparam int ICON_ROW  = 2 * GROUP_ROWS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rowTick,
  input  logic [1:0]          muxMode,
  input  logic                remap,
  input  logic                displayOn,
  output logic [NUM_ROWS-1:0] rowSel,
  output logic                iconRowA,
  output logic                iconRowB,
  output logic                frameStart
);

  scanStrobe_t      strobe;
  muxMode_e         cfgMode;
  logic             cfgRemap;
  logic [IDX_W-1:0] rowIdx;

  lcd_com_scan_ctrl #(.GROUP_ROWS(GROUP_ROWS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rowTick  (rowTick),
    .muxMode  (muxMode),
    .remap    (remap),
    .rowIdx   (rowIdx),
    .strobe   (strobe),
    .cfgMode  (cfgMode),
    .cfgRemap (cfgRemap)
  );

  lcd_com_scan_dp #(.GROUP_ROWS(GROUP_ROWS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .displayOn  (displayOn),
    .rowIdx     (rowIdx),
    .rowSel     (rowSel),
    .iconRowA   (iconRowA),
    .iconRowB   (iconRowB),
    .frameStart (frameStart)
  );

  // R2/R3/R4: the pointer stays inside the sampled arrangement.
  assert_range_R4: assert property (@(posedge clk) disable iff (rst)
    (rowIdx >= IDX_W'(firstRowOf(cfgMode, cfgRemap, GROUP_ROWS))) &&
    (rowIdx <= IDX_W'(lastRowOf(cfgMode, cfgRemap, GROUP_ROWS))));

  // R4: the icon row is only driven in 33-way operation.
  assert_icon_mode_R4: assert property (@(posedge clk) disable iff (rst)
    rowSel[ICON_ROW] |-> (cfgMode == MUX_33));

  // R5: the two icon pins match the icon row line.
  assert_icon_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (iconRowA == rowSel[ICON_ROW]) && (iconRowB == rowSel[ICON_ROW]));

  // R8: a frame pulse coincides with the first row of the arrangement.
  assert_fs_first_R8: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (rowIdx == IDX_W'(firstRowOf(cfgMode, cfgRemap, GROUP_ROWS))));

  // R6: a dark display shows no row.
  assert_dark_R6: assert property (@(posedge clk) disable iff (rst)
    !displayOn |-> (rowSel == '0 && !iconRowA && !iconRowB));

endmodule

// File: tb/lcd_com_scan_tb.sv
module lcd_com_scan_tb;

  localparam int G    = 4;
  localparam int NR   = 2 * G + 1;
  localparam int ICON = 2 * G;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rowTick = 1'b0;
  logic [1:0]    muxMode = 2'b01;
  logic          remap = 1'b0;
  logic          displayOn = 1'b1;
  logic [NR-1:0] rowSel;
  logic          iconRowA, iconRowB, frameStart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  int  mIdx = 0;
  int  mMode = 1;
  bit  mRemap = 0;
  bit  mFs = 0;
  bit  pending = 0;

  always #2 clk = ~clk;

  lcd_com_scan #(.GROUP_ROWS(G)) u_dut (
    .clk(clk), .rst(rst), .rowTick(rowTick), .muxMode(muxMode), .remap(remap),
    .displayOn(displayOn), .rowSel(rowSel), .iconRowA(iconRowA),
    .iconRowB(iconRowB), .frameStart(frameStart)
  );

  function automatic int firstOf(int md, bit rm);
    return (md == 0 && rm) ? G : 0;
  endfunction

  function automatic int lastOf(int md, bit rm);
    if (md == 0) return rm ? 2 * G - 1 : G - 1;
    if (md == 2) return 2 * G;
    return 2 * G - 1;
  endfunction

  function automatic string modeTag(int md, bit rm);
    if (md == 0) return rm ? "R3" : "R2";
    if (md == 2) return "R4";
    return "R1";
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string extra);
    logic [NR-1:0] expSel;
    string tag;
    expSel = displayOn ? (NR'(1) << mIdx) : '0;
    if (extra != "")     tag = extra;
    else if (!displayOn) tag = "R6";
    else if (pending)    tag = "R10";
    else                 tag = modeTag(mMode, mRemap);
    check(rowSel === expSel, tag, "rowSel", longint'(rowSel), longint'(expSel));
    check(iconRowA === expSel[ICON] && iconRowB === expSel[ICON], "R5", "icon pins",
          longint'({iconRowA, iconRowB}), longint'({2{expSel[ICON]}}));
    check(frameStart === mFs, "R8", "frameStart", longint'(frameStart), longint'(mFs));
    check($countones(rowSel) <= 1, "R11", "onehot", longint'($countones(rowSel)), 1);
  endtask

  // Called at a falling edge with inputs already set.
  task automatic cycle(string extra = "");
    @(posedge clk);
    if (rst) begin
      mIdx = firstOf(int'(muxMode), remap);
      mMode = int'(muxMode);
      mRemap = remap;
      mFs = 0;
      pending = 0;
    end else if (rowTick) begin
      if (mIdx == lastOf(mMode, mRemap)) begin
        mIdx = firstOf(int'(muxMode), remap);
        mMode = int'(muxMode);
        mRemap = remap;
        mFs = 1;
        pending = 0;
      end else begin
        mIdx++;
        mFs = 0;
      end
    end else begin
      mFs = 0;
    end
    @(negedge clk);
    checkAll(extra);
  endtask

  task automatic doReset(int md, bit rm);
    muxMode = 2'(md);
    remap = rm;
    rst = 1'b1;
    rowTick = 1'b1;
    cycle("R9");
    cycle("R9");
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Full sweep of each arrangement with continuous ticks (R1-style per mode)
    for (int md = 0; md < 4; md++) begin
      for (int rm = 0; rm < 2; rm++) begin
        displayOn = 1'b1;
        doReset(md, 1'(rm));
        rowTick = 1'b1;
        for (int c = 0; c < 3 * NR; c++) cycle();
        // R7: ticks with gaps, including held rows
        for (int c = 0; c < 4 * NR; c++) begin
          rowTick = (c % 3) != 1;
          cycle((c % 3) == 1 ? "R7" : "");
        end
        // R6: dark display while the scan keeps running
        displayOn = 1'b0;
        rowTick = 1'b1;
        for (int c = 0; c < NR + 2; c++) cycle("R6");
        displayOn = 1'b1;
        for (int c = 0; c < NR; c++) cycle();
      end
    end

    // R10: every ordered pair of arrangements changed mid-frame
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        displayOn = 1'b1;
        doReset(a >> 1, 1'(a & 1));
        rowTick = 1'b1;
        cycle();
        muxMode = 2'(b >> 1);
        remap = 1'(b & 1);
        pending = 1;
        for (int c = 0; c < 3 * NR; c++) cycle();
      end
    end

    // R9: reset in the middle of a frame returns to the first row
    doReset(0, 1'b1);
    rowTick = 1'b1;
    cycle();
    cycle();
    doReset(2, 1'b0);
    rowTick = 1'b0;
    cycle("R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule